// File: doc/BRIEF.md
# Protected-Register Unlock Sequencer

This block holds a lock that guards protected control bits elsewhere in the chip. Software opens the lock by writing a fixed three-byte key to one dedicated key address on the register bus. The bytes must arrive in order. Once the last byte has been accepted, the block raises a single unlock flag. Neighbouring register blocks AND that flag into the write enables of their protected fields. Fields that are exempt from protection ignore the flag and stay writable at all times.

The block watches every bus write. A write to the key address either advances the matcher, restarts it, or closes an open lock. Writes to any other address pass by without effect on the matcher. A read of the key address returns the lock state in bit 0.

The key bytes, the key length, the key address and the bus widths are parameters.

Top module: `regprot_unlock`

## Requirements
- R1: After a synchronous reset the lock is closed: `unlocked` is 0, a read of the key address returns 0, and the matcher is at its initial step.
- R2: Writing the low bytes 0x59, 0x16 and 0x88, in that order, to key address 0x5000_0100 opens the lock. `unlocked` goes to 1 in the clock cycle after the write that carries the third byte.
- R3: While the lock is closed, a key-address write whose low byte is not the next expected byte sends the matcher back to its initial step. The one exception is a mismatched byte equal to 0x59, which leaves the matcher having completed step one.
- R4: While the lock is open, a write of any value to the key address closes it. `unlocked` returns to 0 in the following cycle, and the matcher restarts at its initial step.
- R5: Cycles with no write, and writes to any address other than the key address, leave the matcher's progress and the lock state unchanged.
- R6: When `bus_ren` is high and `bus_addr` equals the key address, `bus_rdata` bit 0 equals `unlocked` and all other bits are 0. In all other cases `bus_rdata` is 0.
- R7: Only bits [7:0] of `bus_wdata` are compared with the key. The upper bits have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wen | input | 1 | Write strobe, one write per cycle when high |
| bus_ren | input | 1 | Read strobe |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| unlocked | output | 1 | High while protected writes are permitted |

## Verification
Several rules are checked on every cycle by the assertions:
- the lock opens only from a key-address write that carries the final key byte;
- an open lock always closes after a key-address write;
- an unexpected non-first byte always resets the matcher;
- the matcher never moves in a cycle without a key-address write;
- read data outside a key-register read is zero.

Some behaviour can only be shown by the bench's scenarios, which check it against a reference model:
- that the full ordered key really does open the lock;
- restart cases such as a repeated 0x59 followed by the rest of the key;
- that interleaved foreign writes, including writes to the neighbouring word, do not break a key in progress;
- that key bytes carried with non-zero upper data bits still match.

// File: rtl/regprot_pkg.sv
package regprot_pkg;

  // Byte idx (0 = first written) of a key packed MSB-first into seq, n bytes long.
  function automatic logic [7:0] key_byte(input logic [63:0] seq, input int n, input int idx);
    return seq[(n-1-idx)*8 +: 8];
  endfunction

  // Next matcher step for a closed lock: advance, restart at one, or restart at zero.
  function automatic int step_after(input logic hit_expected, input logic hit_first, input int cur);
    if (hit_expected) return cur + 1;
    if (hit_first)    return 1;
    return 0;
  endfunction

endpackage

// File: rtl/regprot_addr_dec.sv
module regprot_addr_dec #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] KEY_ADDR = 32'h5000_0100
) (
  input  logic              wen,
  input  logic              ren,
  input  logic [ADDR_W-1:0] addr,
  output logic              key_wr,
  output logic              key_rd
);
  logic hit;
  assign hit    = (addr == KEY_ADDR[ADDR_W-1:0]);
  assign key_wr = wen & hit;
  assign key_rd = ren & hit;
endmodule

// File: rtl/regprot_key_match.sv
module regprot_key_match
  import regprot_pkg::*;
#(
  parameter int                  NUM_KEYS = 3,
  parameter logic [NUM_KEYS*8-1:0] KEY_SEQ = 24'h59_16_88
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] wbyte,
  output logic       open_o
);
  localparam int SW = $clog2(NUM_KEYS + 1);
  localparam logic [SW-1:0] OPEN_STEP = SW'(NUM_KEYS);
  localparam logic [63:0] SEQ64 = 64'(KEY_SEQ);

  logic [SW-1:0]       step_q, step_d;
  logic [NUM_KEYS-1:0] byte_hit;
  logic                hit_expected, hit_first, is_open;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_cmp
    assign byte_hit[k] = (wbyte == key_byte(SEQ64, NUM_KEYS, k));
  end

  assign is_open      = (step_q == OPEN_STEP);
  assign hit_first    = byte_hit[0];

  always_comb begin
    hit_expected = 1'b0;
    for (int k = 0; k < NUM_KEYS; k++)
      if (step_q == SW'(k)) hit_expected = byte_hit[k];
  end

  always_comb begin
    step_d = step_q;
    if (key_wr) begin
      if (is_open) step_d = '0;
      else         step_d = SW'(step_after(hit_expected, hit_first, int'(step_q)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end

  assign open_o = is_open;

  // R2: the lock only opens on a key write carrying the final byte
  a_r2_open_on_last: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> ($past(key_wr) && $past(wbyte) == key_byte(SEQ64, NUM_KEYS, NUM_KEYS-1)));

  // R4: any key write while open closes the lock
  a_r4_relock: assert property (@(posedge clk) disable iff (rst)
    (open_o && key_wr) |=> (!open_o && step_q == '0));

  // R3: an unexpected byte other than the first key byte resets progress
  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    (key_wr && !open_o && !hit_expected && !hit_first) |=> (step_q == '0));

  // R5: no key write, no movement
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(step_q));
endmodule

// File: rtl/regprot_unlock.sv
module regprot_unlock #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] KEY_ADDR = 32'h5000_0100,
  parameter int          NUM_KEYS = 3,
  parameter logic [NUM_KEYS*8-1:0] KEY_SEQ = 24'h59_16_88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              unlocked
);
  logic key_wr, key_rd;

  regprot_addr_dec #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_dec (
    .wen(bus_wen), .ren(bus_ren), .addr(bus_addr),
    .key_wr(key_wr), .key_rd(key_rd)
  );

  regprot_key_match #(.NUM_KEYS(NUM_KEYS), .KEY_SEQ(KEY_SEQ)) u_match (
    .clk(clk), .rst(rst), .key_wr(key_wr), .wbyte(bus_wdata[7:0]), .open_o(unlocked)
  );

  always_comb begin
    bus_rdata = '0;
    if (key_rd) bus_rdata[0] = unlocked;
  end

  // R6: read data is zero outside a key-register read
  a_r6_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
    !key_rd |-> (bus_rdata == '0));
endmodule

// File: tb/regprot_unlock_bench.sv
module regprot_unlock_bench;
  localparam logic [31:0] KADDR = 32'h5000_0100;

  logic        clk = 0, rst = 1, bus_wen = 0, bus_ren = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic        unlocked;
  int checks = 0, errors = 0, exp_step = 0;

  always #2 clk = ~clk;

  regprot_unlock u_regprot_unlock (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlocked(unlocked)
  );

  function automatic logic [7:0] want_byte(int s);
    case (s) 0: return 8'h59; 1: return 8'h16; default: return 8'h88; endcase
  endfunction

  function automatic int model_next(int s, logic [31:0] a, logic [31:0] d);
    if (a != KADDR) return s;
    if (s == 3) return 0;
    if (d[7:0] == want_byte(s)) return s + 1;
    if (d[7:0] == 8'h59) return 1;
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, string req);
    @(negedge clk);
    bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 0;
    exp_step = model_next(exp_step, a, d);
    check(req, {31'd0, unlocked}, {31'd0, exp_step == 3});
  endtask

  task automatic rd(logic [31:0] a, string req);
    @(negedge clk);
    bus_ren = 1; bus_addr = a;
    #1;
    check(req, bus_rdata, (a == KADDR) ? {31'd0, exp_step == 3} : 32'd0);
    bus_ren = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h1234);
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset unlocked", {31'd0, unlocked}, 32'd0);
    rd(KADDR, "R1 reset read");
    // R2 plain key
    wr(KADDR, 32'h59, "R2 k1"); wr(KADDR, 32'h16, "R2 k2"); wr(KADDR, 32'h88, "R2 k3");
    check("R2 open", {31'd0, unlocked}, 32'd1);
    rd(KADDR, "R6 read open");
    rd(KADDR + 4, "R6 other addr read");
    // R4 relock with a key byte
    wr(KADDR, 32'h59, "R4 relock");
    check("R4 closed", {31'd0, unlocked}, 32'd0);
    // R3 wrong byte mid-sequence
    wr(KADDR, 32'h59, "R3 a"); wr(KADDR, 32'h16, "R3 b"); wr(KADDR, 32'h17, "R3 bad");
    wr(KADDR, 32'h88, "R3 stale last");
    check("R3 stays closed", {31'd0, unlocked}, 32'd0);
    // R3 repeated first byte restarts at step one
    wr(KADDR, 32'h59, "R3 r1"); wr(KADDR, 32'h59, "R3 r2");
    wr(KADDR, 32'h16, "R3 r3"); wr(KADDR, 32'h88, "R3 r4");
    check("R3 59 restart opens", {31'd0, unlocked}, 32'd1);
    wr(KADDR, 32'h0, "R4 relock zero");
    wr(KADDR, 32'h59, "R3 s1"); wr(KADDR, 32'h16, "R3 s2"); wr(KADDR, 32'h59, "R3 s3");
    wr(KADDR, 32'h16, "R3 s4"); wr(KADDR, 32'h88, "R3 s5");
    check("R3 mid 59 opens", {31'd0, unlocked}, 32'd1);
    wr(KADDR, 32'hFFFF_FFFF, "R4 relock ones");
    // R5 foreign writes interleaved
    wr(KADDR, 32'h59, "R5 a"); wr(KADDR + 4, 32'h16, "R5 near");
    wr(32'h0, 32'h00, "R5 zero addr"); wr(KADDR, 32'h16, "R5 b");
    repeat (5) @(negedge clk);
    wr(KADDR - 4, 32'h88, "R5 near below"); wr(KADDR, 32'h88, "R5 c");
    check("R5 open after interleave", {31'd0, unlocked}, 32'd1);
    wr(KADDR, 32'h1, "R4 relock");
    // R7 upper bits ignored
    wr(KADDR, 32'hAB00_0059, "R7 a"); wr(KADDR, 32'h1234_5616, "R7 b");
    wr(KADDR, 32'hFFFF_FF88, "R7 c");
    check("R7 open", {31'd0, unlocked}, 32'd1);
    rd(KADDR, "R6 read after R7");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, d;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 7) ? KADDR : ((pick == 7) ? KADDR + 4 : $urandom);
      pick = $urandom_range(0, 4);
      d = $urandom;
      if (pick < 4) d[7:0] = want_byte(pick % 3);
      if ($urandom_range(0, 5) == 0) rd(KADDR, "R6 random read");
      else wr(a, d, "R2 R3 R4 R5 random");
    end
    // reset mid-open
    wr(KADDR, 32'h1, "R4 pre"); exp_step = 0;
    wr(KADDR, 32'h59, "R2 x"); wr(KADDR, 32'h16, "R2 y"); wr(KADDR, 32'h88, "R2 z");
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; exp_step = 0;
    check("R1 reset closes", {31'd0, unlocked}, 32'd0);
    wr(KADDR, 32'h16, "R1 initial step"); wr(KADDR, 32'h88, "R1 initial step 2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule